// File: doc/BRIEF.md
# Three-Channel Capture/Compare Timer

A 16-bit up-counter shared by three independent channels. Its tick rate comes from a prescaler that divides the clock by 1, 8, 32 or 128. Software writes registers to set the divide ratio, the terminal count, the per-channel mode and the per-channel compare values. The counter runs from zero up to the terminal count, then returns to zero and raises an overflow event.

Each channel is set up on its own and works in one of four modes:

- **off**: the output is held low.
- **capture**: the current count is latched when a chosen edge arrives on the channel's input pin.
- **toggle**: the output flips each time the count matches the compare value.
- **PWM**: the output is high while the count is below the compare value.

Compare values are double-buffered. While the counter runs, a new value takes effect only when the counter wraps, so a PWM waveform never shows a partial-period glitch. Channel events and the overflow event are kept in sticky flags that software clears by writing ones.

Top module: `tri_timer`

## Requirements
- R1: After reset the count, every channel output, every capture value and every flag read 0, and the terminal count is 16'hFFFF.
- R2: Register 0 holds the prescaler select in bits [1:0] and the run bit in bit 2. While running, the count advances once every 1, 8, 32 or 128 clocks for select values 0, 1, 2 and 3. While the run bit is 0 the count holds.
- R3: Register 1 holds the terminal count. On a tick where the count is at or above it, the count returns to 0 and the overflow flag sets. Otherwise a tick adds one.
- R4: A channel in PWM mode (mode code 3) drives its output high exactly while the count is below its active compare value. An active compare value of 0 keeps the output low.
- R5: Registers 2, 3 and 4 hold the compare values of channels 0, 1 and 2. While running, a written value becomes active only on the next wrap. While stopped, it becomes active one clock after the write.
- R6: A channel in toggle mode (mode code 2) inverts its output and sets its flag on each tick that finds the count equal to its active compare value. In any other mode the toggle output is reset to 0.
- R7: A channel in capture mode (mode code 1) takes its input through a two-flop synchronizer. On a selected edge it latches the count into its capture value and sets its flag. Edge-select bit 0 enables rising edges and bit 1 enables falling edges.
- R8: Register 5 configures the channels: channel i has its mode in bits [4i+1:4i] and its edge select in bits [4i+3:4i+2]. Writing register 6 clears channel flag i for each data bit i set, and clears the overflow flag for bit 3. Flags are otherwise sticky, and a set event in the same cycle wins over a clear.
- R9: A channel in off mode (mode code 0), or in capture mode, holds its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| cap_in | input | 3 | Capture input pins, one per channel |
| ch_out | output | 3 | Channel outputs (toggle or PWM) |
| count | output | 16 | Current counter value |
| cap_value | output | 48 | Capture values, channel i in bits [16i+15:16i] |
| ch_flag | output | 3 | Sticky channel event flags |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench writes a compare value in the middle of a PWM period and then checks the output both before and after the next wrap. A design that loads compare values immediately would cut the period short and produce a glitch pulse. Random runs include:

- terminal counts of 0;
- terminal counts written below the current count;
- compare values of 0 and compare values above the terminal count;
- prescaler changes made while the prescaler is part-way through a divide.

A design with an off-by-one terminal compare, a stale divider, or a PWM output that leaks high at a zero compare would drift from the bench's model within a few ticks. Capture edges arrive with every edge-select setting, and flag clears land in the same cycles as new events. This exposes a missing synchronizer stage, edges caught on the wrong polarity, and a clear that wins over a set.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  localparam int ADDR_W = 3;
  localparam int PRE_W  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd5;
  localparam logic [ADDR_W-1:0] A_FCLR   = 3'd6;

  typedef enum logic [1:0] {
    CH_OFF     = 2'd0,
    CH_CAPTURE = 2'd1,
    CH_TOGGLE  = 2'd2,
    CH_PWM     = 2'd3
  } ch_mode_e;

  // last prescaler state for each select code (ratio minus one)
  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
    logic [PRE_W-1:0] r;
    case (sel)
      2'd0:    r = PRE_W'(0);
      2'd1:    r = PRE_W'(7);
      2'd2:    r = PRE_W'(31);
      default: r = PRE_W'(127);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tri_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] last;

  always_comb begin
    last  = div_last(sel);
    tick  = run && (pre_q >= last);
    if (!run || tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    wrap  = tick && (cnt_q >= period);
    cnt_d = cnt_q;
    if (wrap) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tri_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ch_mode_e     mode,
  input  logic [1:0]   edge_sel,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         load_act,
  input  logic [W-1:0] count,
  input  logic         tick,
  input  logic         cap_in,
  output logic         ch_out,
  output logic [W-1:0] cmp_act,
  output logic [W-1:0] cap_value,
  output logic         hit
);

  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] act_q, act_d;
  logic [W-1:0] cap_q, cap_d;
  logic [2:0]   sync_q;
  logic         tog_q, tog_d;
  logic         rise, fall, cap_hit, match;

  always_comb begin
    rise    = sync_q[1] && !sync_q[2];
    fall    = !sync_q[1] && sync_q[2];
    cap_hit = (mode == CH_CAPTURE) && ((edge_sel[0] && rise) || (edge_sel[1] && fall));
    match   = (mode == CH_TOGGLE) && tick && (count == act_q);
    hit     = cap_hit || match;

    sh_d  = cmp_wr   ? cmp_wdata : sh_q;
    act_d = load_act ? sh_q      : act_q;
    cap_d = cap_hit  ? count     : cap_q;

    if (mode != CH_TOGGLE) begin
      tog_d = 1'b0;
    end else if (match) begin
      tog_d = !tog_q;
    end else begin
      tog_d = tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      act_q  <= '0;
      cap_q  <= '0;
      sync_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], cap_in};
      tog_q  <= tog_d;
      if (cmp_wr) begin
        sh_q <= sh_d;
      end
      if (load_act) begin
        act_q <= act_d;
      end
      if (cap_hit) begin
        cap_q <= cap_d;
      end
    end
  end

  always_comb begin
    case (mode)
      CH_PWM:    ch_out = (count < act_q);
      CH_TOGGLE: ch_out = tog_q;
      default:   ch_out = 1'b0;
    endcase
  end

  assign cmp_act   = act_q;
  assign cap_value = cap_q;

endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    ch_out,
  output logic [W-1:0]      count,
  output logic [NCH*W-1:0]  cap_value,
  output logic [NCH-1:0]    ch_flag,
  output logic              ovf_flag
);

  localparam int CFG_W = 4 * NCH;
  localparam int FLG_W = NCH + 1;

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [2:0]       ctrl_q, ctrl_d;
  logic [W-1:0]     period_q, period_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [FLG_W-1:0] flag_q, flag_d;
  logic [FLG_W-1:0] clr_vec;
  logic [FLG_W-1:0] set_vec;
  logic             wr_ctrl, wr_period, wr_cfg;
  logic             run, tick, wrap, load_act;
  logic [NCH-1:0]   ch_ev;
  logic [2*NCH-1:0] mode_vec;
  logic [NCH*W-1:0] cmp_act_flat;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    wr_period = wr_en && (wr_addr == A_PERIOD);
    wr_cfg    = wr_en && (wr_addr == A_CFG);
    clr_vec   = (wr_en && (wr_addr == A_FCLR)) ? wr_data[FLG_W-1:0] : '0;
    set_vec   = {wrap, ch_ev};

    ctrl_d    = wr_ctrl   ? wr_data[2:0]       : ctrl_q;
    period_d  = wr_period ? wr_data            : period_q;
    cfg_d     = wr_cfg    ? wr_data[CFG_W-1:0] : cfg_q;
    flag_d    = (flag_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q   <= '0;
      period_q <= '1;
      cfg_q    <= '0;
      flag_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_ctrl) begin
        ctrl_q <= ctrl_d;
      end
      if (wr_period) begin
        period_q <= period_d;
      end
      if (wr_cfg) begin
        cfg_q <= cfg_d;
      end
    end
  end

  assign run      = ctrl_q[2];
  assign load_act = !run || wrap;

  tmr_prescaler i_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .sel   (ctrl_q[1:0]),
    .tick  (tick)
  );

  tmr_counter #(.W(W)) i_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .period (period_q),
    .count  (count),
    .wrap   (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign mode_vec[2*i +: 2] = cfg_q[4*i +: 2];

    tmr_channel #(.W(W)) i_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .mode      (ch_mode_e'(mode_vec[2*i +: 2])),
      .edge_sel  (cfg_q[4*i+2 +: 2]),
      .cmp_wr    (wr_en && (wr_addr == (A_CMP0 + ADDR_W'(i)))),
      .cmp_wdata (wr_data),
      .load_act  (load_act),
      .count     (count),
      .tick      (tick),
      .cap_in    (cap_in[i]),
      .ch_out    (ch_out[i]),
      .cmp_act   (cmp_act_flat[i*W +: W]),
      .cap_value (cap_value[i*W +: W]),
      .hit       (ch_ev[i])
    );
  end

  assign ch_flag  = flag_q[NCH-1:0];
  assign ovf_flag = flag_q[NCH];

endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             wrap,
  input logic [W-1:0]     period,
  input logic [W-1:0]     count,
  input logic [NCH*W-1:0] cmp_act,
  input logic [2*NCH-1:0] mode_vec,
  input logic [NCH:0]     flag_clr,
  input logic [NCH-1:0]   ch_out,
  input logic [NCH-1:0]   ch_flag,
  input logic             ovf_flag
);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == $past(count) + W'(1)) || (count == '0)));

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (count >= period)) |=> ovf_flag);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr[NCH]) |=> ovf_flag);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_cmp_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act[i*W +: W] != $past(cmp_act[i*W +: W])) |-> ($past(!run) || $past(wrap)));

    assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[2*i +: 2] == 2'd0) |-> !ch_out[i]);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_flag[i] && !flag_clr[i]) |=> ch_flag[i]);
  end

endmodule

bind tri_timer tri_timer_chk #(.W(W), .NCH(NCH)) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run      (run),
  .tick     (tick),
  .wrap     (wrap),
  .period   (period_q),
  .count    (count),
  .cmp_act  (cmp_act_flat),
  .mode_vec (mode_vec),
  .flag_clr (clr_vec),
  .ch_out   (ch_out),
  .ch_flag  (ch_flag),
  .ovf_flag (ovf_flag)
);

// File: tb/test_tri_timer.sv
module test_tri_timer;

  localparam int LIMIT = 150000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  cap_in;
  logic [2:0]  ch_out;
  logic [15:0] count;
  logic [47:0] cap_value;
  logic [2:0]  ch_flag;
  logic        ovf_flag;

  int n_chk;
  int n_fail;
  int cyc;
  bit chk_en;
  bit done;

  tri_timer i_tri_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_in(cap_in), .ch_out(ch_out), .count(count), .cap_value(cap_value),
    .ch_flag(ch_flag), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- reference model built from the requirements ----------------
  logic        m_run;
  logic [1:0]  m_sel;
  logic [15:0] m_per;
  logic [11:0] m_cfg;
  logic [6:0]  m_pre;
  logic [15:0] m_cnt;
  logic [15:0] m_sh  [3];
  logic [15:0] m_act [3];
  logic [15:0] m_cap [3];
  logic        m_tog [3];
  logic [2:0]  m_s1, m_s2, m_s3;
  logic [2:0]  m_chf;
  logic        m_ovf;

  function automatic logic [6:0] ratio_last(input logic [1:0] s);
    return (s == 2'd0) ? 7'd0 : (s == 2'd1) ? 7'd7 : (s == 2'd2) ? 7'd31 : 7'd127;
  endfunction

  function automatic logic exp_out(input int ch);
    logic [1:0] md;
    md = m_cfg[4*ch +: 2];
    if (md == 2'd3) return m_cnt < m_act[ch];
    if (md == 2'd2) return m_tog[ch];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    logic       tk, wr;
    logic [2:0] ev;
    logic [3:0] clr;
    if (!rst_n) begin
      m_run = 0; m_sel = 0; m_per = 16'hFFFF; m_cfg = 0; m_pre = 0; m_cnt = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_chf = 0; m_ovf = 0;
      for (int i = 0; i < 3; i++) begin
        m_sh[i] = 0; m_act[i] = 0; m_cap[i] = 0; m_tog[i] = 0;
      end
    end else begin
      tk  = m_run && (m_pre >= ratio_last(m_sel));
      wr  = tk && (m_cnt >= m_per);
      clr = (wr_en && wr_addr == 3'd6) ? wr_data[3:0] : 4'd0;
      for (int i = 0; i < 3; i++) begin
        logic [1:0] md, es;
        logic       hit_c, hit_t;
        md    = m_cfg[4*i +: 2];
        es    = m_cfg[4*i+2 +: 2];
        hit_c = (md == 2'd1) && ((es[0] && m_s2[i] && !m_s3[i]) || (es[1] && !m_s2[i] && m_s3[i]));
        hit_t = (md == 2'd2) && tk && (m_cnt == m_act[i]);
        ev[i] = hit_c || hit_t;
        if (hit_c) m_cap[i] = m_cnt;
        m_tog[i] = (md != 2'd2) ? 1'b0 : (hit_t ? !m_tog[i] : m_tog[i]);
        if (!m_run || wr) m_act[i] = m_sh[i];
      end
      m_chf = (m_chf & ~clr[2:0]) | ev;
      m_ovf = (m_ovf & ~clr[3]) | wr;
      m_pre = (!m_run || tk) ? 7'd0 : m_pre + 7'd1;
      m_cnt = wr ? 16'd0 : (tk ? m_cnt + 16'd1 : m_cnt);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_sel = wr_data[1:0]; m_run = wr_data[2]; end
          3'd1: m_per = wr_data;
          3'd2: m_sh[0] = wr_data;
          3'd3: m_sh[1] = wr_data;
          3'd4: m_sh[2] = wr_data;
          3'd5: m_cfg = wr_data[11:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(count == m_cnt, "R2 count", count, m_cnt);
      check(ovf_flag == m_ovf, "R3 overflow flag", ovf_flag, m_ovf);
      check(ch_flag == m_chf, "R8 channel flags", ch_flag, m_chf);
      for (int i = 0; i < 3; i++) begin
        logic e;
        e = exp_out(i);
        if (ch_out[i] != e) begin
          case (m_cfg[4*i +: 2])
            2'd3:    check(1'b0, "R4 pwm output", ch_out[i], e);
            2'd2:    check(1'b0, "R6 toggle output", ch_out[i], e);
            default: check(1'b0, "R9 idle output", ch_out[i], e);
          endcase
        end else begin
          check(1'b1, "R4", 0, 0);
        end
        check(cap_value[16*i +: 16] == m_cap[i], "R7 capture value", cap_value[16*i +: 16], m_cap[i]);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      n_fail++;
      $display("FAIL watchdog: run exceeded %0d cycles", LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_count(input logic [15:0] v);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (count == v) break;
    end
  endtask

  initial begin
    logic [15:0] cur_per;
    n_chk = 0; n_fail = 0; cyc = 0; chk_en = 0; done = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cap_in = '0;
    repeat (4) @(negedge clk);
    // R1: reset state seen at the ports
    check(count == 16'd0, "R1 count after reset", count, 0);
    check(ch_out == 3'd0, "R1 outputs after reset", ch_out, 0);
    check(ch_flag == 3'd0 && ovf_flag == 1'b0, "R1 flags after reset", {ch_flag, ovf_flag}, 0);
    check(cap_value == 48'd0, "R1 capture after reset", cap_value, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;

    // R1: terminal count 16'hFFFF after reset -- free run reaches 300 with no overflow
    wr(3'd0, 16'h0004);
    wait_count(16'd300);
    check(ovf_flag == 1'b0, "R1 default terminal count", ovf_flag, 0);
    wr(3'd0, 16'h0000);

    // R5: compare written mid-period waits for the wrap
    wr(3'd5, 16'h0003);          // channel 0 PWM
    wr(3'd1, 16'd99);
    wr(3'd2, 16'd50);
    wr(3'd6, 16'h000F);
    wr(3'd0, 16'h0000);
    wait_count(16'd300);
    wr(3'd0, 16'h0004);
    wait_count(16'd0);
    wait_count(16'd20);
    wr(3'd2, 16'd10);
    wait_count(16'd30);
    check(ch_out[0] == 1'b1, "R5 old compare kept before wrap", ch_out[0], 1);
    wait_count(16'd0);
    wait_count(16'd30);
    check(ch_out[0] == 1'b0, "R5 new compare after wrap", ch_out[0], 0);

    // R4: zero compare keeps PWM low
    wr(3'd3, 16'd0);
    wr(3'd5, 16'h0033);
    wait_count(16'd0);
    wait_count(16'd5);
    check(ch_out[1] == 1'b0, "R4 zero compare low", ch_out[1], 0);

    // R7: rising capture on channel 2
    wr(3'd5, 16'h0533);
    wr(3'd6, 16'h000F);
    @(negedge clk); cap_in[2] = 1'b1;
    repeat (4) @(negedge clk);
    check(ch_flag[2] == 1'b1, "R7 capture flag", ch_flag[2], 1);

    // constrained random mixed traffic (R2, R3, R6, R8, R9 via the model)
    cur_per = 16'd99;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 16;
      case (r)
        0, 1, 2: wr(3'd2 + 3'(r), 16'($urandom % (32'(cur_per) + 3)));
        3: begin cur_per = 16'($urandom % 200); wr(3'd1, cur_per); end
        4: wr(3'd0, {13'd0, ($urandom % 5 != 0), (($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0)});
        5: wr(3'd5, 16'($urandom % 4096));
        6: wr(3'd6, 16'($urandom % 16));
        7, 8, 9, 10: begin @(negedge clk); cap_in[$urandom % 3] ^= 1'b1; end
        default: repeat ($urandom % 20) @(negedge clk);
      endcase
      repeat ($urandom % 6) @(negedge clk);
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule